// File: doc/BRIEF.md
# Colour Palette Host Access Controller

This block connects an 8-bit processor bus to a colour lookup memory of 256 entries, each 18 bits wide. The host controls it with two active-low strobes, one for read and one for write, a 2-bit register select and an 8-bit data path. An address register chooses the entry. A hidden three-state phase counter walks the host through the colour components one byte at a time: red, then green, then blue. Writes collect red and green in staging registers. The blue write commits all three components to memory as one 18-bit word. Reads are served from an 18-bit holding register, which is refilled from memory whenever the address changes.

The strobes are asynchronous to the system clock. Each is passed through a synchroniser and acts on its rising (release) edge. Software normally loads an address once and then streams colour triplets. The address advances by itself after each full triplet and wraps at the top of the table. A pixel mask register shares the same bus and is driven out to the pixel-side logic.

Top module: `palette_host_ctrl`

## Requirements
- R1: A write with select 00 loads the 8-bit address register from the data bus and puts the phase counter back to red. A triplet that was half written before the load is abandoned.
- R2: With select 01, successive accesses carry red, then green, then blue. The phase counter takes the values red=0, green=1 and blue=2, and steps on each read or write access.
- R3: The blue write stores the word {red[5:0], green[5:0], blue[5:0]} (red in bits 17:12) at the current address. The address then increases by one.
- R4: A blue read increases the address by one. Red and green reads leave the address unchanged.
- R5: Colour bytes use data bits 5:0. Bits 7:6 are ignored on writes and read as zero.
- R6: A blue access at address FFh wraps the address to 00h, on both the write and the read path.
- R7: Reading with select 00 returns the address register and changes neither the address nor the phase counter.
- R8: When both strobes are low at the same time, the access is void. No register, phase or memory state changes when the strobes are released.
- R9: Select 10 reads and writes the 8-bit pixel mask, which is also driven on `pixMask`. Select 11 reads zero, and writes to it are ignored.
- R10: After reset the address is 00h, the phase is red and the pixel mask is FFh.
- R11: The holding register is refilled from memory after each address load and after each blue access. A read triplet therefore returns the entry at the current address, including entries reached by auto-increment.
- R12: Each blue write raises `ramWe` for exactly one clock, with `ramAddr` and `ramWdata` showing the entry and the word being stored. No other access raises `ramWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdN | input | 1 | Host read strobe, active low, asynchronous |
| wrN | input | 1 | Host write strobe, active low, asynchronous |
| regSel | input | 2 | Register select: 00 address, 01 colour, 10 mask, 11 unused |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Read data for the selected register |
| pixMask | output | 8 | Current pixel mask value |
| ramWe | output | 1 | Memory write strobe for a committed colour |
| ramAddr | output | 8 | Entry being written |
| ramWdata | output | 18 | Word being written, red in the upper field |

## Verification
The states that are hardest to reach from the ports are those where the hidden phase counter is partway through a triplet while something else happens. The bench creates them on purpose: it reads the address between a red write and a green write, loads a fresh address after a lone red write, reads the address between green and blue reads, and drops both strobes together in the middle of a colour sequence. In each case the correct phase can only be confirmed later, when a complete triplet lands in the right entry with its components in the right fields. Full sweeps over all 256 entries on the write path and the read path also carry the address through the FFh-to-00h wrap.

// File: rtl/palette_host_pkg.sv
package palette_host_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  localparam logic [1:0] SEL_ADDR  = 2'b00;
  localparam logic [1:0] SEL_COLOR = 2'b01;
  localparam logic [1:0] SEL_MASK  = 2'b10;

  typedef struct packed {
    logic addrLoad;
    logic maskLoad;
    logic latchRed;
    logic latchGreen;
    logic commitBlue;
    logic readStep;
  } hostStrobe_t;

endpackage

// File: rtl/host_strobe_sync.sv
module host_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rdN,
  input  logic wrN,
  output logic rdRise,
  output logic wrRise
);

  logic [STAGES-1:0] rdPipe;
  logic [STAGES-1:0] wrPipe;
  logic rdPrev, wrPrev;
  logic collide;
  logic rdHigh, wrHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPipe[0] <= 1'b1;
      wrPipe[0] <= 1'b1;
    end else begin
      rdPipe[0] <= rdN;
      wrPipe[0] <= wrN;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPipe[s] <= 1'b1;
        wrPipe[s] <= 1'b1;
      end else begin
        rdPipe[s] <= rdPipe[s-1];
        wrPipe[s] <= wrPipe[s-1];
      end
    end
  end

  assign rdHigh = rdPipe[STAGES-1];
  assign wrHigh = wrPipe[STAGES-1];

  // Sticky overlap flag: set while both strobes are low, cleared once both are high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev  <= 1'b1;
      wrPrev  <= 1'b1;
      collide <= 1'b0;
    end else begin
      rdPrev <= rdHigh;
      wrPrev <= wrHigh;
      if (!rdHigh && !wrHigh)     collide <= 1'b1;
      else if (rdHigh && wrHigh)  collide <= 1'b0;
    end
  end

  assign rdRise = rdHigh && !rdPrev && !collide;
  assign wrRise = wrHigh && !wrPrev && !collide;

endmodule

// File: rtl/host_seq_ctrl.sv
module host_seq_ctrl
  import palette_host_pkg::*;
(
  input  logic        rdRise,
  input  logic        wrRise,
  input  logic [1:0]  regSel,
  input  phase_t      phase,
  output hostStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (wrRise) begin
      unique case (regSel)
        SEL_ADDR:  strobe.addrLoad = 1'b1;
        SEL_MASK:  strobe.maskLoad = 1'b1;
        SEL_COLOR: begin
          unique case (phase)
            PH_RED:   strobe.latchRed   = 1'b1;
            PH_GREEN: strobe.latchGreen = 1'b1;
            PH_BLUE:  strobe.commitBlue = 1'b1;
            default:  ;
          endcase
        end
        default: ;
      endcase
    end else if (rdRise && regSel == SEL_COLOR) begin
      strobe.readStep = 1'b1;
    end
  end

endmodule

// File: rtl/host_dpath.sv
module host_dpath
  import palette_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COMP_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         strobe,
  input  logic [1:0]          regSel,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output phase_t              phase,
  output logic [ADDR_W-1:0]   addrQ,
  output logic [ADDR_W-1:0]   maskQ,
  output logic                ramWe,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [3*COMP_W-1:0] ramWdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 3 * COMP_W;
  localparam int PAD_W  = DATA_W - COMP_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [COMP_W-1:0] redQ, greenQ;
  logic [WORD_W-1:0] holdQ;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] loadAddr;
  logic [COMP_W-1:0] compIn;
  logic [COMP_W-1:0] compOut;

  assign addrNext = addrQ + ADDR_W'(1);
  assign loadAddr = dataIn[ADDR_W-1:0];
  assign compIn   = dataIn[COMP_W-1:0];

  assign ramWe    = strobe.commitBlue;
  assign ramAddr  = addrQ;
  assign ramWdata = {redQ, greenQ, compIn};

  always_ff @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      phase  <= PH_RED;
      maskQ  <= '1;
      redQ   <= '0;
      greenQ <= '0;
      holdQ  <= '0;
    end else begin
      if (strobe.addrLoad) begin
        addrQ <= loadAddr;
        phase <= PH_RED;
        holdQ <= mem[loadAddr];
      end
      if (strobe.maskLoad) maskQ <= dataIn[ADDR_W-1:0];
      if (strobe.latchRed) begin
        redQ  <= compIn;
        phase <= PH_GREEN;
      end
      if (strobe.latchGreen) begin
        greenQ <= compIn;
        phase  <= PH_BLUE;
      end
      if (strobe.commitBlue) begin
        phase <= PH_RED;
        addrQ <= addrNext;
        holdQ <= mem[addrNext];
      end
      if (strobe.readStep) begin
        if (phase == PH_BLUE) begin
          phase <= PH_RED;
          addrQ <= addrNext;
          holdQ <= mem[addrNext];
        end else begin
          phase <= phase_t'(phase + 2'd1);
        end
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_GREEN: compOut = holdQ[COMP_W +: COMP_W];
      PH_BLUE:  compOut = holdQ[0 +: COMP_W];
      default:  compOut = holdQ[2*COMP_W +: COMP_W];
    endcase
  end

  always_comb begin
    unique case (regSel)
      SEL_ADDR:  dataOut = DATA_W'(addrQ);
      SEL_COLOR: dataOut = {{PAD_W{1'b0}}, compOut};
      SEL_MASK:  dataOut = DATA_W'(maskQ);
      default:   dataOut = '0;
    endcase
  end

endmodule

// File: rtl/palette_host_ctrl.sv
module palette_host_ctrl
  import palette_host_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int COMP_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic [1:0]          regSel,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic [ADDR_W-1:0]   pixMask,
  output logic                ramWe,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [3*COMP_W-1:0] ramWdata
);

  logic        rdRise, wrRise;
  hostStrobe_t strobe;
  phase_t      phaseQ;
  logic [ADDR_W-1:0] addrQ;

  host_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN),
    .rdRise(rdRise), .wrRise(wrRise)
  );

  host_seq_ctrl u_ctrl (
    .rdRise(rdRise), .wrRise(wrRise), .regSel(regSel),
    .phase(phaseQ), .strobe(strobe)
  );

  host_dpath #(.ADDR_W(ADDR_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .dataIn(dataIn), .dataOut(dataOut), .phase(phaseQ), .addrQ(addrQ),
    .maskQ(pixMask), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );

endmodule

// File: rtl/palette_host_chk.sv
module palette_host_chk #(
  parameter int ADDR_W = 8,
  parameter int COMP_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [1:0]        phaseQ,
  input logic [ADDR_W-1:0] addrQ,
  input logic [1:0]        regSel,
  input logic [DATA_W-1:0] dataOut
);

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ != 2'd3); // R2

  AST_COMMIT_ON_BLUE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> phaseQ == 2'd2); // R12

  AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> phaseQ == 2'd0 && !ramWe); // R3

  AST_COMMIT_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> addrQ == $past(addrQ) + ADDR_W'(1)); // R3

  AST_TOP_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramAddr == {ADDR_W{1'b1}}) |=> addrQ == '0); // R6

  AST_COLOR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regSel == 2'b01 |-> dataOut[DATA_W-1:COMP_W] == '0); // R5

endmodule

bind palette_host_ctrl palette_host_chk #(.ADDR_W(ADDR_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ramWe(ramWe), .ramAddr(ramAddr),
  .phaseQ(phaseQ), .addrQ(addrQ), .regSel(regSel), .dataOut(dataOut)
);

// File: tb/sim_palette_host_ctrl.sv
`timescale 1ns/1ps
module sim_palette_host_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdN = 1'b1, wrN = 1'b1;
  logic [1:0] regSel = 2'b00;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut, pixMask, ramAddr;
  logic ramWe;
  logic [17:0] ramWdata;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  int weCount = 0;
  logic [7:0]  lastWeAddr;
  logic [17:0] lastWeData;

  always #2 clk = ~clk;

  palette_host_ctrl u0 (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .regSel(regSel),
    .dataIn(dataIn), .dataOut(dataOut), .pixMask(pixMask),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );

  always @(negedge clk) begin
    if (rstN && ramWe) begin
      weCount++;
      lastWeAddr = ramAddr;
      lastWeData = ramWdata;
    end
  end

  function automatic logic [5:0] colR(int i); return 6'((i * 5 + 1) & 63); endfunction
  function automatic logic [5:0] colG(int i); return 6'((i * 7 + 3) & 63); endfunction
  function automatic logic [5:0] colB(int i); return 6'((i ^ 8'hAA) & 63); endfunction

  task automatic chk(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; dataIn = d; wrN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; rdN = 1'b0;
    repeat (3) @(negedge clk);
    d = dataOut;
    rdN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostBoth(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; dataIn = d; wrN = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1; rdN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic writeTriplet(input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
    hostWrite(2'b01, {2'b11, r});
    hostWrite(2'b01, {2'b01, g});
    hostWrite(2'b01, {2'b10, b});
  endtask

  task automatic readTriplet(input string tag, input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
    logic [7:0] v;
    hostRead(2'b01, v); chk({tag, " red"},   v, {2'b00, r});
    hostRead(2'b01, v); chk({tag, " green"}, v, {2'b00, g});
    hostRead(2'b01, v); chk({tag, " blue"},  v, {2'b00, b});
  endtask

  initial begin
    logic [7:0] v;
    int weBefore;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    hostRead(2'b00, v); chk("R10 reset address", v, 8'h00);
    hostRead(2'b10, v); chk("R10 reset mask", v, 8'hFF);
    chk("R10 reset pixMask port", pixMask, 8'hFF);
    chk("R12 no write at reset", weCount, 0);

    // Write sweep over every entry, R3 R5 R12
    hostWrite(2'b00, 8'h00);
    for (int i = 0; i < 256; i++) begin
      weBefore = weCount;
      hostWrite(2'b01, {2'b11, colR(i)});
      hostWrite(2'b01, {2'b01, colG(i)});
      chk("R12 no write on red/green", weCount, weBefore);
      hostWrite(2'b01, {2'b10, colB(i)});
      chk("R12 one write per triplet", weCount, weBefore + 1);
      chk("R12 write address", lastWeAddr, i);
      chk("R3 R5 write word", lastWeData, {colR(i), colG(i), colB(i)});
    end
    hostRead(2'b00, v); chk("R6 write path wrap", v, 8'h00);

    // Read sweep, R2 R4 R7 R11
    hostWrite(2'b00, 8'h00);
    for (int i = 0; i < 256; i++) begin
      if (i == 10) begin
        hostRead(2'b01, v); chk("R2 red", v, {2'b00, colR(i)});
        hostRead(2'b01, v); chk("R2 green", v, {2'b00, colG(i)});
        hostRead(2'b00, v); chk("R4 R7 no step before blue", v, i);
        hostRead(2'b01, v); chk("R7 blue after address read", v, {2'b00, colB(i)});
        hostRead(2'b00, v); chk("R4 step after blue", v, i + 1);
      end else begin
        readTriplet("R2 R11 sweep", colR(i), colG(i), colB(i));
      end
    end
    hostRead(2'b00, v); chk("R6 read path wrap", v, 8'h00);

    // R6 explicit top entry on read
    hostWrite(2'b00, 8'hFF);
    readTriplet("R6 top entry", colR(255), colG(255), colB(255));
    hostRead(2'b00, v); chk("R6 read wrap to zero", v, 8'h00);

    // R9 mask and unused select
    hostWrite(2'b10, 8'h3C);
    hostRead(2'b10, v); chk("R9 mask read", v, 8'h3C);
    chk("R9 pixMask port", pixMask, 8'h3C);
    hostWrite(2'b11, 8'h55);
    hostRead(2'b11, v); chk("R9 unused select reads zero", v, 8'h00);
    hostRead(2'b10, v); chk("R9 mask unaffected by select 11", v, 8'h3C);
    hostRead(2'b00, v); chk("R9 address unaffected by select 11", v, 8'h00);

    // R8 overlapping strobes
    hostWrite(2'b00, 8'h40);
    weBefore = weCount;
    hostBoth(2'b00, 8'h77);
    hostRead(2'b00, v); chk("R8 address kept", v, 8'h40);
    hostWrite(2'b01, 8'h11);
    hostBoth(2'b01, 8'h22);
    hostWrite(2'b01, 8'h05);
    hostBoth(2'b01, 8'h33);
    hostWrite(2'b01, 8'h2B);
    chk("R8 only the real blue commits", weCount, weBefore + 1);
    chk("R8 word intact", lastWeData, {6'h11, 6'h05, 6'h2B});
    hostWrite(2'b00, 8'h40);
    readTriplet("R8 readback", 6'h11, 6'h05, 6'h2B);

    // R1 address load abandons partial triplet
    hostWrite(2'b00, 8'h50);
    hostWrite(2'b01, 8'h3F);
    hostWrite(2'b00, 8'h50);
    writeTriplet(6'h01, 6'h02, 6'h03);
    chk("R1 commit address", lastWeAddr, 8'h50);
    chk("R1 fresh triplet", lastWeData, {6'h01, 6'h02, 6'h03});

    // R7 address read between red and green writes
    hostWrite(2'b00, 8'h20);
    hostWrite(2'b01, 8'h0A);
    hostRead(2'b00, v); chk("R7 address read mid write", v, 8'h20);
    hostWrite(2'b01, 8'h0B);
    hostWrite(2'b01, 8'h0C);
    chk("R7 phase undisturbed", lastWeData, {6'h0A, 6'h0B, 6'h0C});
    hostRead(2'b00, v); chk("R3 address after commit", v, 8'h21);

    // R11 prefetch follows auto-increment after a write commit
    readTriplet("R11 next entry", colR(33), colG(33), colB(33));
    hostWrite(2'b00, 8'h1F);
    readTriplet("R11 before", colR(31), colG(31), colB(31));
    readTriplet("R11 rewritten", 6'h0A, 6'h0B, 6'h0C);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule